// File: doc/BRIEF.md
# Status Flags and Branch Evaluator

This block is the flag-generation and condition-testing slice of a small integer datapath. An 8-bit arithmetic, logic and shift unit combines two operands into a result. When the flag-enable input is asserted, the carry, sign, zero and overflow bits of that result are captured in a four-bit status register. A combinational evaluator reads the stored flags and, for a 4-bit condition selector, reports whether a conditional branch would be taken.

The conditions cover eight single-flag tests plus eight compare tests. The compare tests assume that the last flag-writing operation was the subtraction A minus B, computed as A + ~B + 1. A stored carry of 1 therefore means no borrow. Unsigned and signed orderings of A and B are read directly from the flags.

Program counter update and instruction decoding belong to the surrounding core and are not part of this block.

Top module: `flag_branch_unit`

## Requirements
- R1: After reset all four stored flags are 0, so selector 1 (not zero) reads taken and selector 0 (zero) reads not taken.
- R2: The combinational result follows the operation code: 0 add A+B, 1 subtract A−B, 2 A AND B, 3 A OR B, 4 A XOR B, 5 shift A left by one with a zero filled in, 6 shift A right logically by one, 7 complement of A.
- R3: For add, the stored carry is the carry out of bit 7. For subtract, it is 1 exactly when A ≥ B unsigned (no borrow).
- R4: For add and subtract, the stored overflow is set on two's-complement overflow (carry into bit 7 XOR carry out of bit 7). For a left shift it is A[7] XOR A[6].
- R5: The stored sign equals result bit 7, and the stored zero is 1 exactly when all eight result bits are 0.
- R6: Operations 2, 3, 4 and 7 store carry 0 and overflow 0. A left shift stores A[7] as carry and a right shift stores A[0], with overflow 0 for the right shift.
- R7: On a clock edge with flag enable low, the stored flags keep their value whatever the operands and operation.
- R8: Single-flag selectors: 0 Z, 1 not Z, 2 C, 3 not C, 4 not S, 5 S, 6 V, 7 not V.
- R9: Unsigned compare selectors: 8 higher (C and not Z), 9 higher-or-same (C), 10 lower (not C), 11 lower-or-same (not C or Z).
- R10: Signed compare selectors: 12 greater (not (S xor V) and not Z), 13 greater-or-equal (not (S xor V)), 14 less (S xor V), 15 less-or-equal ((S xor V) or Z).
- R11: The branch output reads the stored flags. Flags written at a clock edge affect it from that edge on, and in the cycle that produces them it still reflects the earlier flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| aluOp | input | 3 | Operation code (see R2) |
| flagEn | input | 1 | Capture the new flags at the next edge |
| condSel | input | 4 | Branch condition selector (see R8–R10) |
| result | output | 8 | Combinational operation result |
| carryFlag | output | 1 | Stored carry |
| signFlag | output | 1 | Stored sign |
| zeroFlag | output | 1 | Stored zero |
| overflowFlag | output | 1 | Stored overflow |
| branchTaken | output | 1 | Selected condition holds on the stored flags |

## Verification
A flag write and a branch evaluation can share a cycle: a compare with flag enable high can be presented together with a condition selector that reads the flags it is about to replace. The bench drives such cycles and samples the branch output twice. Before the edge it must follow the previous flags. After the edge it must follow the flags the compare produced. The two samples are judged against separate expectations held in the scoreboard entry.

// File: rtl/flag_pkg.sv
package flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_NOT = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } logicSel_e;

  typedef enum logic [3:0] {
    CND_ZERO   = 4'd0,
    CND_NZERO  = 4'd1,
    CND_CARRY  = 4'd2,
    CND_NCARRY = 4'd3,
    CND_PLUS   = 4'd4,
    CND_MINUS  = 4'd5,
    CND_OVF    = 4'd6,
    CND_NOVF   = 4'd7,
    CND_UHI    = 4'd8,
    CND_UHS    = 4'd9,
    CND_ULO    = 4'd10,
    CND_ULS    = 4'd11,
    CND_SGT    = 4'd12,
    CND_SGE    = 4'd13,
    CND_SLT    = 4'd14,
    CND_SLE    = 4'd15
  } cond_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      useArith;
    logic      useLogic;
    logic      useShift;
    logic      invertB;
    logic      carryIn;
    logicSel_e logicSel;
    logic      shiftLeft;
    logic      loadFlags;
  } strobe_t;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

endpackage

// File: rtl/flag_control.sv
module flag_control
  import flag_pkg::*;
(
  input  logic [2:0] aluOp,
  input  logic       flagEn,
  output strobe_t    strobe
);

  always_comb begin
    strobe           = '0;
    strobe.logicSel  = LG_AND;
    strobe.loadFlags = flagEn;
    case (aluOp_e'(aluOp))
      OP_ADD: strobe.useArith = 1'b1;
      OP_SUB: begin
        strobe.useArith = 1'b1;
        strobe.invertB  = 1'b1;
        strobe.carryIn  = 1'b1;
      end
      OP_AND: begin
        strobe.useLogic = 1'b1;
        strobe.logicSel = LG_AND;
      end
      OP_OR: begin
        strobe.useLogic = 1'b1;
        strobe.logicSel = LG_OR;
      end
      OP_XOR: begin
        strobe.useLogic = 1'b1;
        strobe.logicSel = LG_XOR;
      end
      OP_SHL: begin
        strobe.useShift  = 1'b1;
        strobe.shiftLeft = 1'b1;
      end
      OP_SHR: strobe.useShift = 1'b1;
      default: begin
        strobe.useLogic = 1'b1;
        strobe.logicSel = LG_NOT;
      end
    endcase
  end

endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  strobe_t          strobe,
  output logic [WIDTH-1:0] result,
  output flags_t           flagsQ
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] lowSum;
  logic [1:0]       msbSum;
  logic             carryIntoMsb;
  logic [WIDTH-1:0] arithRes;
  logic             arithC;
  logic             arithV;
  logic [WIDTH-1:0] logicRes;
  logic [WIDTH-1:0] shiftRes;
  logic             shiftC;
  logic             shiftV;
  logic             nextC;
  logic             nextV;
  flags_t           flagsD;

  // adder split at the top bit so carry-in and carry-out of the msb are both visible
  assign bEff         = strobe.invertB ? ~opB : opB;
  assign lowSum       = {1'b0, opA[MSB-1:0]} + {1'b0, bEff[MSB-1:0]}
                        + {{(WIDTH-1){1'b0}}, strobe.carryIn};
  assign carryIntoMsb = lowSum[MSB];
  assign msbSum       = {1'b0, opA[MSB]} + {1'b0, bEff[MSB]} + {1'b0, carryIntoMsb};
  assign arithRes     = {msbSum[0], lowSum[MSB-1:0]};
  assign arithC       = msbSum[1];
  assign arithV       = carryIntoMsb ^ msbSum[1];

  always_comb begin
    case (strobe.logicSel)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = ~opA;
    endcase
  end

  always_comb begin
    if (strobe.shiftLeft) begin
      shiftRes = {opA[MSB-1:0], 1'b0};
      shiftC   = opA[MSB];
      shiftV   = opA[MSB] ^ opA[MSB-1];
    end else begin
      shiftRes = {1'b0, opA[MSB:1]};
      shiftC   = opA[0];
      shiftV   = 1'b0;
    end
  end

  always_comb begin
    result = logicRes;
    nextC  = 1'b0;
    nextV  = 1'b0;
    if (strobe.useArith) begin
      result = arithRes;
      nextC  = arithC;
      nextV  = arithV;
    end else if (strobe.useShift) begin
      result = shiftRes;
      nextC  = shiftC;
      nextV  = shiftV;
    end
  end

  assign flagsD = '{c: nextC, s: result[MSB], z: ~|result, v: nextV};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 flagsQ <= '0;
    else if (strobe.loadFlags) flagsQ <= flagsD;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadFlags |=> $stable(flagsQ));

  p_logic_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadFlags && strobe.useLogic) |=> (!flagsQ.c && !flagsQ.v));

  p_sign_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFlags |=> (flagsQ.s == $past(result[MSB])) && (flagsQ.z == ($past(result) == '0)));

endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import flag_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] condSel,
  output logic       taken
);

  logic signLess;

  assign signLess = flags.s ^ flags.v;

  always_comb begin
    case (cond_e'(condSel))
      CND_ZERO:   taken = flags.z;
      CND_NZERO:  taken = !flags.z;
      CND_CARRY:  taken = flags.c;
      CND_NCARRY: taken = !flags.c;
      CND_PLUS:   taken = !flags.s;
      CND_MINUS:  taken = flags.s;
      CND_OVF:    taken = flags.v;
      CND_NOVF:   taken = !flags.v;
      CND_UHI:    taken = flags.c && !flags.z;
      CND_UHS:    taken = flags.c;
      CND_ULO:    taken = !flags.c;
      CND_ULS:    taken = !flags.c || flags.z;
      CND_SGT:    taken = !signLess && !flags.z;
      CND_SGE:    taken = !signLess;
      CND_SLT:    taken = signLess;
      default:    taken = signLess || flags.z;
    endcase
  end

endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       aluOp,
  input  logic             flagEn,
  input  logic [3:0]       condSel,
  output logic [WIDTH-1:0] result,
  output logic             carryFlag,
  output logic             signFlag,
  output logic             zeroFlag,
  output logic             overflowFlag,
  output logic             branchTaken
);

  strobe_t strobe;
  flags_t  flagsQ;

  flag_control u_control (
    .aluOp  (aluOp),
    .flagEn (flagEn),
    .strobe (strobe)
  );

  flag_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (result),
    .flagsQ (flagsQ)
  );

  branch_eval u_branch (
    .flags   (flagsQ),
    .condSel (condSel),
    .taken   (branchTaken)
  );

  assign carryFlag    = flagsQ.c;
  assign signFlag     = flagsQ.s;
  assign zeroFlag     = flagsQ.z;
  assign overflowFlag = flagsQ.v;

  // a compare just written must order the operands it came from
  p_unsigned_hi_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(flagEn) && ($past(aluOp) == OP_SUB) && (condSel == CND_UHI))
      |-> (branchTaken == ($past(opA) > $past(opB))));

  p_signed_lt_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(flagEn) && ($past(aluOp) == OP_SUB) && (condSel == CND_SLT))
      |-> (branchTaken == ($signed($past(opA)) < $signed($past(opB)))));

endmodule

// File: tb/tb_flag_branch_unit.sv
module tb_flag_branch_unit;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [2:0] aluOp = '0;
  logic       flagEn = 1'b0;
  logic [3:0] condSel = '0;
  logic [7:0] result;
  logic       carryFlag, signFlag, zeroFlag, overflowFlag, branchTaken;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [7:0] expRes;
    logic [3:0] expFlags;   // {C,S,Z,V}
    logic       expPre;
    logic       expPost;
    string      tag;
  } item_t;

  item_t sbQ[$];
  logic [3:0] model = '0;

  flag_branch_unit dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .aluOp(aluOp),
    .flagEn(flagEn), .condSel(condSel), .result(result),
    .carryFlag(carryFlag), .signFlag(signFlag), .zeroFlag(zeroFlag),
    .overflowFlag(overflowFlag), .branchTaken(branchTaken)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic evalCond(input logic [3:0] f, input logic [3:0] c);
    logic fc, fs, fz, fv;
    {fc, fs, fz, fv} = f;
    case (c)
      4'd0: return fz;
      4'd1: return !fz;
      4'd2: return fc;
      4'd3: return !fc;
      4'd4: return !fs;
      4'd5: return fs;
      4'd6: return fv;
      4'd7: return !fv;
      4'd8: return fc && !fz;
      4'd9: return fc;
      4'd10: return !fc;
      4'd11: return !fc || fz;
      4'd12: return !(fs ^ fv) && !fz;
      4'd13: return !(fs ^ fv);
      4'd14: return fs ^ fv;
      default: return (fs ^ fv) || fz;
    endcase
  endfunction

  // reference model from the requirements
  task automatic refOp(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op,
                       output logic [7:0] r, output logic [3:0] f);
    logic c, v;
    logic [8:0] wide;
    c = 1'b0; v = 1'b0;
    case (op)
      3'd0: begin wide = {1'b0, a} + {1'b0, b}; r = wide[7:0]; c = wide[8];
              v = (a[7] == b[7]) && (r[7] != a[7]); end
      3'd1: begin r = a - b; c = (a >= b); v = (a[7] != b[7]) && (r[7] != a[7]); end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      3'd5: begin r = {a[6:0], 1'b0}; c = a[7]; v = a[7] ^ a[6]; end
      3'd6: begin r = {1'b0, a[7:1]}; c = a[0]; end
      default: r = ~a;
    endcase
    f = {c, r[7], (r == 8'd0), v};
  endtask

  // driver: presents one cycle of stimulus and queues its expectations
  task automatic step(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op,
                      input logic en, input logic [3:0] cs, input string tag);
    item_t it;
    logic [7:0] r;
    logic [3:0] f;
    @(negedge clk);
    opA = a; opB = b; aluOp = op; flagEn = en; condSel = cs;
    refOp(a, b, op, r, f);
    it.expPre = evalCond(model, cs);
    if (en) model = f;
    it.expRes = r;
    it.expFlags = model;
    it.expPost = evalCond(model, cs);
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  function automatic string condTag(input int c);
    if (c < 8) return "R8";
    else if (c < 12) return "R9";
    else return "R10";
  endfunction

  task automatic sweep(input logic [7:0] a, input logic [7:0] b);
    step(a, b, 3'd1, 1'b1, 4'd8, "R9");
    for (int c = 0; c < 16; c++) step(a, b, 3'd1, 1'b0, c[3:0], condTag(c));
  endtask

  // monitor: compares each queued item before and after its edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (sbQ.size() != 0) begin
        it = sbQ[0];
        check("R11", "branch before edge", branchTaken, it.expPre);
        check(it.tag, "result", result, it.expRes);
        @(posedge clk);
        #(PERIOD/4);
        it = sbQ.pop_front();
        check(it.tag, "flags CSZV", {carryFlag, signFlag, zeroFlag, overflowFlag}, it.expFlags);
        check(it.tag, "branch after edge", branchTaken, it.expPost);
      end
    end
  end

  initial begin
    #(PERIOD * 50000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #(PERIOD/4);
    condSel = 4'd1;
    #1;
    check("R1", "flags after reset", {carryFlag, signFlag, zeroFlag, overflowFlag}, 0);
    check("R1", "not-zero branch after reset", branchTaken, 1);
    condSel = 4'd0;
    #1;
    check("R1", "zero branch after reset", branchTaken, 0);

    // arithmetic
    step(8'h10, 8'h20, 3'd0, 1'b1, 4'd0, "R2");
    step(8'hFF, 8'h01, 3'd0, 1'b1, 4'd2, "R3");
    step(8'h7F, 8'h01, 3'd0, 1'b1, 4'd6, "R4");
    step(8'h80, 8'h80, 3'd0, 1'b1, 4'd0, "R4");
    step(8'h05, 8'h05, 3'd1, 1'b1, 4'd9, "R3");
    step(8'h03, 8'h05, 3'd1, 1'b1, 4'd10, "R3");
    step(8'h80, 8'h01, 3'd1, 1'b1, 4'd14, "R4");
    step(8'h00, 8'h00, 3'd1, 1'b1, 4'd0, "R5");
    // logic after C and V were set
    step(8'hFF, 8'h01, 3'd0, 1'b1, 4'd2, "R3");
    step(8'hF0, 8'h3C, 3'd2, 1'b1, 4'd2, "R6");
    step(8'h80, 8'h80, 3'd0, 1'b1, 4'd6, "R4");
    step(8'h0F, 8'h80, 3'd3, 1'b1, 4'd6, "R6");
    step(8'hAA, 8'hAA, 3'd4, 1'b1, 4'd0, "R5");
    step(8'hFF, 8'h12, 3'd7, 1'b1, 4'd0, "R6");
    step(8'h35, 8'h00, 3'd7, 1'b1, 4'd5, "R2");
    // shifts
    step(8'hC0, 8'h00, 3'd5, 1'b1, 4'd2, "R6");
    step(8'h40, 8'h00, 3'd5, 1'b1, 4'd6, "R4");
    step(8'h01, 8'h00, 3'd6, 1'b1, 4'd0, "R6");
    step(8'h82, 8'h00, 3'd6, 1'b1, 4'd4, "R2");
    // hold with enable low
    step(8'h80, 8'h80, 3'd0, 1'b1, 4'd0, "R4");
    step(8'h01, 8'h02, 3'd0, 1'b0, 4'd0, "R7");
    step(8'h00, 8'h01, 3'd1, 1'b0, 4'd3, "R7");
    step(8'h00, 8'hFF, 3'd2, 1'b0, 4'd6, "R7");
    // same-cycle write and read of the flags
    step(8'h09, 8'h03, 3'd1, 1'b1, 4'd10, "R11");
    step(8'h03, 8'h09, 3'd1, 1'b1, 4'd10, "R11");
    // condition sweeps over compare outcomes
    sweep(8'h09, 8'h03);
    sweep(8'h03, 8'h09);
    sweep(8'h07, 8'h07);
    sweep(8'h80, 8'h01);
    sweep(8'h01, 8'h80);
    sweep(8'h7F, 8'hFF);
    sweep(8'hFE, 8'hFF);
    // single-flag selectors after a negative, overflowing add
    step(8'h7F, 8'h7F, 3'd0, 1'b1, 4'd5, "R8");
    for (int c = 0; c < 8; c++) step(8'h00, 8'h00, 3'd0, 1'b0, c[3:0], "R8");

    repeat (3) @(posedge clk);
    #(PERIOD/4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule